// File: doc/BRIEF.md
# Configuration SPI Port with Read Unlock

This block is a serial configuration port for a sensor front end. A host drives chip select, a serial clock and one shared data line. Every frame is sixteen clock periods long: a command byte followed by a data byte, each sent most significant bit first. The port holds three registers:

- a configuration byte whose fields leave the block as separate control ports;
- an eight-bit offset DAC code;
- a key register that can only be written.

Out of reset the port accepts writes only. Read-back turns on after two key bytes are written to the key register in back-to-back frames. While read-back is on, a read command makes the block take over the shared data line for the data byte of that frame. It hands the line back when the frame ends or when chip select rises.

All three serial pins are synchronized into a faster system clock, and their edges are detected there. The data line is split into an input, an output and an output enable. The pad sits outside the block.

Top module: `afe_cfg_port`

## Requirements
- R1: After reset the configuration byte is 0x00, the DAC code is 0x80, read-back is off and the data line is not driven.
- R2: A write frame whose command byte is 0x00 loads the data byte into the configuration byte. The byte appears on the ports as follows: bit 7 is channel select; bits 6:5 are the stage-2 and stage-1 enables (`stage_en[1]` and `stage_en[0]`); bit 4 is the external filter path; bit 3 is the high common-mode select; bits 2:1 are the second-stage gain code (00=4, 01=8, 10=16, 11=32); bit 0 selects the low first-stage gain (0=250, 1=42).
- R3: A write frame whose command byte is 0x01 loads the data byte into the DAC code.
- R4: In the command byte, bit 7 is 1 for a read and 0 for a write, bits 6:4 must be zero, and bits 3:0 are the address. A command with any of bits 6:4 set, or a write to an address other than 0x0, 0x1 or 0xF, leaves every register unchanged.
- R5: While read-back is off, a read frame never drives the data line.
- R6: Read-back turns on only when 0xFE is written to address 0xF and the next completed frame writes 0xED to address 0xF. Any other completed frame in between cancels the sequence.
- R7: While read-back is on, a valid read drives the data line from the falling clock edge that follows the 8th rising edge. The register is shifted out MSB first and changes on falling edges. Any number of reads may follow one another.
- R8: The data line is released after the 16th rising clock edge, or as soon as chip select rises.
- R9: Raising chip select before the 16th rising edge abandons the frame with no register update, and the next frame starts cleanly from bit 0.
- R10: Writing to address 0xF any value other than the completing 0xED turns read-back off. While read-back is on, a read of address 0xF or of an unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles high |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Read data toward the pad |
| sdio_oe | output | 1 | Pad output enable |
| chan_sel | output | 1 | Input channel select |
| stage_en | output | 2 | Amplifier stage enables |
| filt_ext | output | 1 | Route between stages through the external filter |
| cm_hi | output | 1 | High common-mode level select |
| gain2_code | output | 2 | Second-stage gain code |
| gain1_low | output | 1 | Low first-stage gain select |
| dac_code | output | 8 | Offset DAC code |

## Verification
The bench builds the port with three synchronizer stages instead of the default two. This lengthens the path from a serial edge to the system-clock edge detector, so the checks on when the output enable rises and falls are made with the longest latency the serial timing still allows. Data width and address width stay at their defaults of eight and four.

With these values, all sixteen bit positions of a frame can be reached, including the mid-frame bus turnaround. So can a chip-select abort after the line has started driving, and the unlock sequence both completed and broken by an intervening frame.

// File: rtl/afe_cfg_pkg.sv
// Package: shared constants and types for the configuration SPI port.
// Assumes an eight-bit register file addressed by four bits.
package afe_cfg_pkg;
    localparam int CFG_DATA_W = 8;
    localparam int CFG_ADDR_W = 4;

    localparam logic [CFG_ADDR_W-1:0] ADDR_CFG = 4'h0;
    localparam logic [CFG_ADDR_W-1:0] ADDR_DAC = 4'h1;
    localparam logic [CFG_ADDR_W-1:0] ADDR_KEY = 4'hF;

    localparam logic [CFG_DATA_W-1:0] KEY_FIRST  = 8'hFE;
    localparam logic [CFG_DATA_W-1:0] KEY_SECOND = 8'hED;
    localparam logic [CFG_DATA_W-1:0] DAC_RESET  = 8'h80;

    // Configuration byte, MSB first; downstream decoders rely on this layout.
    typedef struct packed {
        logic       chan_sel;
        logic [1:0] stage_en;
        logic       filt_ext;
        logic       cm_hi;
        logic [1:0] gain2_code;
        logic       gain1_low;
    } cfg_fields_t;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_ARMED  = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_t;
endpackage

// File: rtl/afe_sync.sv
// Module: multi-flop synchronizer for a group of asynchronous pins.
// Assumes STAGES >= 2; each bit resets to its own idle level from RESET_VAL.
module afe_sync #(
    parameter int             WIDTH     = 3,
    parameter int             STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin through STAGES flops toward the system clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], async_in[g]};
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/afe_frame_engine.sv
// Module: frame engine. Counts serial clock edges, assembles the command and
// data bytes, issues a one-cycle write strobe at the last rising edge and
// shifts read data out on falling edges once the command byte is complete.
// Assumes synchronized pins; sdi is sampled in the same cycle a rise is seen.
module afe_frame_engine #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_lvl,
    input  logic              sck_lvl,
    input  logic              sdi,
    input  logic              unlocked,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic              frame_done,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam int FRAME = 2 * DATA_W;
    localparam int CNT_W = $clog2(FRAME);
    localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] CNT_TURN     = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME - 1);

    logic              sck_prev;
    logic              sck_rise;
    logic              sck_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shnext;
    logic [DATA_W-1:0] cmd_q;
    logic [DATA_W-1:0] tx;
    logic              cmd_ok;
    logic              read_ok;

    // Remember the previous clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b1;
        else        sck_prev <= sck_lvl;
    end

    assign sck_rise = sck_lvl & ~sck_prev;
    assign sck_fall = ~sck_lvl & sck_prev;
    assign shnext   = {shreg[DATA_W-2:0], sdi};
    assign cmd_ok   = (cmd_q[DATA_W-2:ADDR_W] == '0);
    assign read_ok  = cmd_ok & cmd_q[DATA_W-1] & unlocked;
    assign addr     = cmd_q[ADDR_W-1:0];
    assign sdo      = tx[DATA_W-1];

    // Frame sequencing: bit count, byte capture, write strobe, read shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            cmd_q      <= '0;
            wr_data    <= '0;
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            tx         <= '0;
            sdo_oe     <= 1'b0;
        end else begin
            wr_en      <= 1'b0;
            frame_done <= 1'b0;
            if (cs_lvl) begin
                bit_cnt <= '0;
                sdo_oe  <= 1'b0;
            end else if (sck_rise) begin
                shreg   <= shnext;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_CMD_LAST) cmd_q <= shnext;
                if (bit_cnt == CNT_LAST) begin
                    frame_done <= 1'b1;
                    wr_en      <= cmd_ok & ~cmd_q[DATA_W-1];
                    wr_data    <= shnext;
                    sdo_oe     <= 1'b0;
                end
            end else if (sck_fall) begin
                if (bit_cnt == CNT_TURN && read_ok) begin
                    sdo_oe <= 1'b1;
                    tx     <= rd_data;
                end else if (sdo_oe) begin
                    tx <= {tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    AST_IDLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> !sdo_oe) else $error("line driven while deselected"); // R8
    AST_NO_DRIVE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> unlocked) else $error("line driven while locked"); // R5
    AST_TURN_AT_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (bit_cnt == CNT_TURN)) else $error("turnaround at wrong bit"); // R7
    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_lvl |=> (bit_cnt == '0)) else $error("count survived deselect"); // R9
endmodule

// File: rtl/afe_reg_bank.sv
// Module: register bank. Holds the configuration byte, the DAC code and the
// read unlock state, and muxes read data. Assumes wr_en and frame_done are
// one-cycle strobes issued together at the end of a completed frame.
module afe_reg_bank
    import afe_cfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  frame_done,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [CFG_DATA_W-1:0] wr_data,
    output cfg_fields_t           cfg_q,
    output logic [CFG_DATA_W-1:0] dac_q,
    output logic                  unlocked,
    output logic [CFG_DATA_W-1:0] rd_data
);
    key_state_t key_q;
    logic       key_wr;

    assign key_wr   = wr_en && (addr == ADDR_KEY);
    assign unlocked = (key_q == KEY_OPEN);

    // Store configuration and DAC code on their write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dac_q <= DAC_RESET;
        end else if (wr_en) begin
            if (addr == ADDR_CFG) cfg_q <= cfg_fields_t'(wr_data);
            if (addr == ADDR_DAC) dac_q <= wr_data;
        end
    end

    // Track the two-byte unlock sequence across consecutive completed frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= KEY_LOCKED;
        end else if (frame_done) begin
            if (key_wr) begin
                if (wr_data == KEY_FIRST)                              key_q <= KEY_ARMED;
                else if (wr_data == KEY_SECOND && key_q == KEY_ARMED)  key_q <= KEY_OPEN;
                else                                                   key_q <= KEY_LOCKED;
            end else if (key_q == KEY_ARMED) begin
                key_q <= KEY_LOCKED;
            end
        end
    end

    // Select read data; the key register and holes read as zero.
    always_comb begin
        case (addr)
            ADDR_CFG: rd_data = cfg_q;
            ADDR_DAC: rd_data = dac_q;
            default:  rd_data = '0;
        endcase
    end

    AST_OPEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_q == KEY_OPEN) |-> $past(key_q == KEY_ARMED)) else $error("unlock skipped arm"); // R6
    AST_DAC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(dac_q)) else $error("DAC changed outside frame end"); // R9
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(cfg_q)) else $error("config changed outside frame end"); // R4
endmodule

// File: rtl/afe_cfg_port.sv
// Module: top of the configuration SPI port. Synchronizes the serial pins,
// runs the frame engine and register bank, and decodes configuration fields.
// Assumes clk is several times faster than the serial clock.
module afe_cfg_port
    import afe_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sclk,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic       chan_sel,
    output logic [1:0] stage_en,
    output logic       filt_ext,
    output logic       cm_hi,
    output logic [1:0] gain2_code,
    output logic       gain1_low,
    output logic [7:0] dac_code
);
    logic [2:0]            pins_sync;
    logic                  wr_en;
    logic                  frame_done;
    logic [CFG_ADDR_W-1:0] addr;
    logic [CFG_DATA_W-1:0] wr_data;
    logic [CFG_DATA_W-1:0] rd_data;
    logic                  unlocked;
    cfg_fields_t           cfg_q;

    afe_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b011)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({sdio_in, spi_sclk, spi_cs_n}),
        .sync_out (pins_sync)
    );

    afe_frame_engine #(.DATA_W(CFG_DATA_W), .ADDR_W(CFG_ADDR_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_lvl     (pins_sync[0]),
        .sck_lvl    (pins_sync[1]),
        .sdi        (pins_sync[2]),
        .unlocked   (unlocked),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .frame_done (frame_done),
        .addr       (addr),
        .wr_data    (wr_data),
        .sdo        (sdio_out),
        .sdo_oe     (sdio_oe)
    );

    afe_reg_bank u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .frame_done (frame_done),
        .addr       (addr),
        .wr_data    (wr_data),
        .cfg_q      (cfg_q),
        .dac_q      (dac_code),
        .unlocked   (unlocked),
        .rd_data    (rd_data)
    );

    assign chan_sel   = cfg_q.chan_sel;
    assign stage_en   = cfg_q.stage_en;
    assign filt_ext   = cfg_q.filt_ext;
    assign cm_hi      = cfg_q.cm_hi;
    assign gain2_code = cfg_q.gain2_code;
    assign gain1_low  = cfg_q.gain1_low;
endmodule

// File: tb/afe_cfg_port_test.sv
// Bench: behavioural model of registers and unlock state, compared with the
// port outputs on every idle clock and at every serial bit of each frame.
module afe_cfg_port_test;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic mosi = 1'b0;
    logic sdio_out, sdio_oe, chan_sel, filt_ext, cm_hi, gain1_low;
    logic [1:0] stage_en, gain2_code;
    logic [7:0] dac_code;

    int compared = 0;
    int mismatched = 0;
    bit busy = 1'b1;
    bit done = 1'b0;

    // Model state.
    logic [7:0] m_cfg = 8'h00;
    logic [7:0] m_dac = 8'h80;
    int         m_key = 0;   // 0 locked, 1 armed, 2 open

    always #2 clk = ~clk;

    afe_cfg_port #(.SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .sdio_in(mosi), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .chan_sel(chan_sel), .stage_en(stage_en), .filt_ext(filt_ext),
        .cm_hi(cm_hi), .gain2_code(gain2_code), .gain1_low(gain1_low),
        .dac_code(dac_code)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] cfg_port();
        return {chan_sel, stage_en, filt_ext, cm_hi, gain2_code, gain1_low};
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        if (a == 4'h0) return m_cfg;
        if (a == 4'h1) return m_dac;
        return 8'h00;
    endfunction

    // Every idle clock: outputs must match the model and the line must be free.
    always @(negedge clk) begin
        if (!busy && !done) begin
            chk("R2 config", cfg_port(), m_cfg);
            chk("R3 dac", dac_code, m_dac);
            chk("R8 idle oe", {7'd0, sdio_oe}, 8'h00);
        end
    end

    // One frame; nrises < 16 aborts by raising chip select.
    task automatic frame(input logic [7:0] cmd, input logic [7:0] data, input int nrises);
        bit         rd_drive;
        logic [7:0] exp_rd;
        busy = 1'b1;
        rd_drive = cmd[7] && (cmd[6:4] == 3'b000) && (m_key == 2);
        exp_rd = model_read(cmd[3:0]);
        @(negedge clk) cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (i >= nrises) break;
            sclk = 1'b0;
            mosi = (i < 8) ? cmd[7-i] : (cmd[7] ? 1'b0 : data[15-i]);
            repeat (HALF) @(negedge clk);
            if (rd_drive && i >= 8) begin
                chk("R7 oe", {7'd0, sdio_oe}, 8'h01);
                chk("R7 data bit", {7'd0, sdio_out}, {7'd0, exp_rd[15-i]});
            end else if (cmd[7] && i >= 8) begin
                chk("R5 locked no drive", {7'd0, sdio_oe}, 8'h00);
            end else begin
                chk("R7 no drive before turn", {7'd0, sdio_oe}, 8'h00);
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            if (i == 15) chk("R8 release after last rise", {7'd0, sdio_oe}, 8'h00);
        end
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (HALF) @(negedge clk);
        chk("R8 release on deselect", {7'd0, sdio_oe}, 8'h00);
        if (nrises >= 16) begin
            if (!cmd[7] && cmd[6:4] == 3'b000) begin
                if (cmd[3:0] == 4'h0) m_cfg = data;
                if (cmd[3:0] == 4'h1) m_dac = data;
            end
            if (!cmd[7] && cmd[6:4] == 3'b000 && cmd[3:0] == 4'hF) begin
                if (data == 8'hFE)                     m_key = 1;
                else if (data == 8'hED && m_key == 1)  m_key = 2;
                else                                   m_key = 0;
            end else if (m_key == 1) begin
                m_key = 0;
            end
        end
        repeat (2) @(negedge clk);
        busy = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: an expired run counts as a failure and still summarizes.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R1: reset values
        chk("R1 config reset", cfg_port(), 8'h00);
        chk("R1 dac reset", dac_code, 8'h80);
        chk("R1 oe reset", {7'd0, sdio_oe}, 8'h00);
        busy = 1'b0;
        repeat (4) @(negedge clk);

        // R2: field mapping
        frame(8'h00, 8'hA5, 16);
        chk("R2 chan_sel", {7'd0, chan_sel}, 8'h01);
        chk("R2 stage_en", {6'd0, stage_en}, 8'h01);
        chk("R2 filt_ext", {7'd0, filt_ext}, 8'h00);
        chk("R2 cm_hi", {7'd0, cm_hi}, 8'h00);
        chk("R2 gain2_code", {6'd0, gain2_code}, 8'h02);
        chk("R2 gain1_low", {7'd0, gain1_low}, 8'h01);
        // R3: DAC code
        frame(8'h01, 8'h3C, 16);
        chk("R3 dac write", dac_code, 8'h3C);
        // R4: reserved bits and unmapped address ignored
        frame(8'h10, 8'hFF, 16);
        frame(8'h41, 8'h00, 16);
        frame(8'h05, 8'h77, 16);
        chk("R4 config untouched", cfg_port(), 8'hA5);
        chk("R4 dac untouched", dac_code, 8'h3C);
        // R5: read while locked
        frame(8'h80, 8'h00, 16);
        // R6: broken sequence stays locked
        frame(8'h0F, 8'hFE, 16);
        frame(8'h01, 8'h3C, 16);
        frame(8'h0F, 8'hED, 16);
        frame(8'h81, 8'h00, 16);
        // R6: proper sequence unlocks
        frame(8'h0F, 8'hFE, 16);
        frame(8'h0F, 8'hED, 16);
        // R7: back-to-back reads
        frame(8'h80, 8'h00, 16);
        frame(8'h81, 8'h00, 16);
        frame(8'h00, 8'h5A, 16);
        frame(8'h80, 8'h00, 16);
        // R10: key and holes read zero
        frame(8'h8F, 8'h00, 16);
        frame(8'h87, 8'h00, 16);
        // R4: read with reserved bits never drives
        frame(8'hC0, 8'h00, 16);
        // R8: deselect mid read releases
        frame(8'h80, 8'h00, 11);
        // R9: aborted write, then a fresh frame
        frame(8'h01, 8'h99, 12);
        chk("R9 abort keeps dac", dac_code, 8'h3C);
        frame(8'h01, 8'hC3, 16);
        chk("R9 fresh frame after abort", dac_code, 8'hC3);
        // R10: relock by writing another key value
        frame(8'h0F, 8'h00, 16);
        frame(8'h81, 8'h00, 16);
        chk("R10 relocked config", cfg_port(), 8'h5A);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule